// File: doc/BRIEF.md
# Multi-Lane Register Rename Table

This block renames registers for a group of frontend lanes that decode together in one cycle. It holds a table that maps each architectural register except register zero to a physical register, with a pending flag per mapping. It also holds a free list of physical registers. In the same cycle, every lane that writes a register can take its own distinct free physical register, and every lane can look up the current mapping of its source registers.

Lanes are ordered from oldest (lane 0) to youngest. Allocation runs down that order. Each lane takes the lowest-numbered free register that no older lane has taken this cycle, and a lane can only succeed when every older lane that asked also succeeded. A source lookup in a lane first reads the table. If an older lane of the same group is renaming that same architectural register in this cycle, the lookup takes the newly chosen register instead and reports it as pending. Completion ports clear pending flags. Free ports give physical registers back to the free list. All table and free-list changes take effect at the next clock edge, and lookups see the state from before that edge.

Top module: `rename_multi`

## Requirements
- R1: After reset, architectural register r maps to physical register r with pending clear. Physical registers NARCH up to NPHYS-1 are free, and all others are not.
- R2: A lookup of a nonzero architectural register that no older lane is renaming this cycle returns the table's physical register and pending flag.
- R3: Two lanes granted in the same cycle never receive the same physical register.
- R4: A lane's alloc_preg is the lowest-numbered free physical register that no older lane was granted this cycle.
- R5: When an older lane is granted a rename of the looked-up architectural register, the lookup returns that lane's new register with pending set. If several older lanes qualify, the youngest of them supplies the register.
- R6: alloc_rdy[i] is high only when a free register is left for lane i and every older lane that requests a nonzero register is itself ready. A lane is granted when its request is high, its register is nonzero and its alloc_rdy is high.
- R7: After a grant, the table entry holds the granted register with pending set, and that register has left the free list from the next cycle. When lanes rename the same register together, the youngest lane's mapping is kept.
- R8: Register zero is never renamed. A lookup of zero returns physical 0 with pending clear. A request naming zero takes no register and does not stop younger lanes.
- R9: A completion clears the pending flag of every table entry that maps the completed physical register, starting from the next cycle. A grant to the same entry in the same cycle wins and leaves pending set.
- R10: A physical register given back on a free port can be allocated from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | NLANES | Per-lane request to rename a destination |
| alloc_areg | input | NLANES x AW | Destination architectural register per lane |
| alloc_rdy | output | NLANES | Lane can be granted this cycle |
| alloc_preg | output | NLANES x PW | Physical register offered to each lane |
| lk_areg | input | NLANES x NSRC x AW | Source architectural registers per lane |
| lk_preg | output | NLANES x NSRC x PW | Physical register for each source |
| lk_pend | output | NLANES x NSRC | Source is still pending |
| comp_val | input | NCOMP | Completion valid per port |
| comp_preg | input | NCOMP x PW | Completed physical register |
| fr_val | input | NFREE | Free valid per port |
| fr_preg | input | NFREE x PW | Physical register given back |

## Verification
The bench targets several corner cases, each of which shows up as a specific wrong result.
- Three lanes renaming the same register while a younger lane reads it: a design that forwards from the oldest match, or reads only the table, returns a stale or wrong register.
- A request for register zero placed between two real requests: mishandling it either consumes a register or blocks the younger lane.
- Running the free list dry and then returning one register: a broken ready chain grants a younger lane beyond the last free register, or misses the returned one.
- A completion and a grant to the same entry in the same cycle: a wrong write order leaves the new mapping reported as ready.

// File: rtl/rename_multi.sv
module rename_multi #(
  parameter int NLANES = 4,
  parameter int NARCH  = 32,
  parameter int NPHYS  = 48,
  parameter int NSRC   = 2,
  parameter int NCOMP  = 2,
  parameter int NFREE  = 2,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NLANES-1:0]                    alloc_req,
  input  logic [NLANES-1:0][AW-1:0]            alloc_areg,
  output logic [NLANES-1:0]                    alloc_rdy,
  output logic [NLANES-1:0][PW-1:0]            alloc_preg,
  input  logic [NLANES-1:0][NSRC-1:0][AW-1:0]  lk_areg,
  output logic [NLANES-1:0][NSRC-1:0][PW-1:0]  lk_preg,
  output logic [NLANES-1:0][NSRC-1:0]          lk_pend,
  input  logic [NCOMP-1:0]                     comp_val,
  input  logic [NCOMP-1:0][PW-1:0]             comp_preg,
  input  logic [NFREE-1:0]                     fr_val,
  input  logic [NFREE-1:0][PW-1:0]             fr_preg
);

  logic [PW-1:0]    map_q [NARCH];
  logic [NARCH-1:0] pend_q;
  logic [NPHYS-1:0] free_q, free_d, avail_w;
  logic [NLANES-1:0][PW-1:0] pick_w;
  logic [NLANES-1:0] take_w, want_w;
  logic chain_w, has_w;

  // Chain of priority encoders, each masked by older lanes' grants
  always_comb begin
    avail_w = free_q;
    chain_w = 1'b1;
    for (int i = 0; i < NLANES; i++) begin
      want_w[i] = alloc_req[i] && (alloc_areg[i] != '0);
      pick_w[i] = '0;
      has_w = 1'b0;
      for (int p = NPHYS-1; p >= 0; p--)
        if (avail_w[p]) begin
          pick_w[i] = PW'(p);
          has_w = 1'b1;
        end
      alloc_rdy[i] = has_w && chain_w;
      take_w[i] = want_w[i] && alloc_rdy[i];
      if (take_w[i]) avail_w[pick_w[i]] = 1'b0;
      if (want_w[i] && !alloc_rdy[i]) chain_w = 1'b0;
    end
  end

  assign alloc_preg = pick_w;

  always_comb begin
    for (int k = 0; k < NLANES; k++)
      for (int s = 0; s < NSRC; s++) begin
        lk_preg[k][s] = map_q[lk_areg[k][s]];
        lk_pend[k][s] = pend_q[lk_areg[k][s]];
        for (int m = 0; m < NLANES; m++)
          if (m < k && take_w[m] && alloc_areg[m] == lk_areg[k][s]) begin
            lk_preg[k][s] = pick_w[m];
            lk_pend[k][s] = 1'b1;
          end
        if (lk_areg[k][s] == '0) begin
          lk_preg[k][s] = '0;
          lk_pend[k][s] = 1'b0;
        end
      end
  end

  always_comb begin
    free_d = free_q;
    for (int i = 0; i < NLANES; i++)
      if (take_w[i]) free_d[pick_w[i]] = 1'b0;
    for (int c = 0; c < NFREE; c++)
      if (fr_val[c]) free_d[fr_preg[c]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NARCH; r++) map_q[r] <= PW'(r);
      pend_q <= '0;
      for (int p = 0; p < NPHYS; p++) free_q[p] <= (p >= NARCH);
    end else begin
      free_q <= free_d;
      for (int r = 1; r < NARCH; r++)
        for (int c = 0; c < NCOMP; c++)
          if (comp_val[c] && map_q[r] == comp_preg[c]) pend_q[r] <= 1'b0;
      for (int i = 0; i < NLANES; i++)
        if (take_w[i]) begin
          map_q[alloc_areg[i]]  <= pick_w[i];
          pend_q[alloc_areg[i]] <= 1'b1;
        end
    end
  end

  genvar gi, gj, gs;
  generate
    for (gi = 0; gi < NLANES; gi++) begin : g_lane_chk
      p_taken_leaves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_w[gi] |=> !free_q[$past(pick_w[gi])]);
      for (gj = gi + 1; gj < NLANES; gj++) begin : g_pair
        p_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
          (take_w[gi] && take_w[gj]) |-> (pick_w[gi] != pick_w[gj]));
      end
      if (gi > 0) begin : g_chain
        p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (alloc_rdy[gi] && alloc_req[gi-1] && alloc_areg[gi-1] != '0) |-> alloc_rdy[gi-1]);
      end
      for (gs = 0; gs < NSRC; gs++) begin : g_src
        p_zero_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
          (lk_areg[gi][gs] == '0) |-> (lk_preg[gi][gs] == '0 && !lk_pend[gi][gs]));
      end
    end
    for (gi = 0; gi < NFREE; gi++) begin : g_free_chk
      p_freed_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fr_val[gi] |=> free_q[$past(fr_preg[gi])]);
    end
  endgenerate

  p_youngest_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_w[NLANES-1] |=> (map_q[$past(alloc_areg[NLANES-1])] == $past(pick_w[NLANES-1]))
                         && pend_q[$past(alloc_areg[NLANES-1])]);

endmodule

// File: tb/sim_rename_multi.sv
`timescale 1ns/1ps
module sim_rename_multi;
  localparam int NL = 4, NA = 32, NP = 48, NS = 2, NC = 2, NF = 2;
  localparam int AW = $clog2(NA), PW = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NL-1:0]                 alloc_req;
  logic [NL-1:0][AW-1:0]         alloc_areg;
  logic [NL-1:0]                 alloc_rdy;
  logic [NL-1:0][PW-1:0]         alloc_preg;
  logic [NL-1:0][NS-1:0][AW-1:0] lk_areg;
  logic [NL-1:0][NS-1:0][PW-1:0] lk_preg;
  logic [NL-1:0][NS-1:0]         lk_pend;
  logic [NC-1:0]                 comp_val;
  logic [NC-1:0][PW-1:0]         comp_preg;
  logic [NF-1:0]                 fr_val;
  logic [NF-1:0][PW-1:0]         fr_preg;

  rename_multi #(.NLANES(NL), .NARCH(NA), .NPHYS(NP), .NSRC(NS), .NCOMP(NC), .NFREE(NF)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_areg(alloc_areg),
    .alloc_rdy(alloc_rdy), .alloc_preg(alloc_preg), .lk_areg(lk_areg), .lk_preg(lk_preg),
    .lk_pend(lk_pend), .comp_val(comp_val), .comp_preg(comp_preg),
    .fr_val(fr_val), .fr_preg(fr_preg));

  int total = 0, bad = 0;
  bit done = 0;
  int m_map [NA];
  bit m_pend [NA];
  bit [NP-1:0] m_free;
  int pool [NP];
  int npool = 0;
  string tag_al = "", tag_lk = "";

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_free(bit [NP-1:0] v);
    for (int p = 0; p < NP; p++) if (v[p]) return p;
    return -1;
  endfunction

  task automatic model_reset();
    for (int r = 0; r < NA; r++) begin m_map[r] = r; m_pend[r] = 0; end
    for (int p = 0; p < NP; p++) m_free[p] = (p >= NA);
    npool = 0;
  endtask

  task automatic idle();
    alloc_req = '0; alloc_areg = '0; lk_areg = '0;
    comp_val = '0; comp_preg = '0; fr_val = '0; fr_preg = '0;
  endtask

  function automatic int pop_pool();
    npool--;
    return pool[npool];
  endfunction

  // Inputs are set at a falling edge; check, advance the model, wait for next falling edge.
  task automatic step();
    int ep [NL];
    bit tk [NL];
    bit [NP-1:0] av;
    bit chain, want, er;
    int a, ex_p, ex_d;
    string t;
    #1;
    av = m_free; chain = 1;
    for (int i = 0; i < NL; i++) begin
      want = alloc_req[i] && alloc_areg[i] != 0;
      ep[i] = low_free(av);
      er = (ep[i] >= 0) && chain;
      chk((tag_al != "") ? tag_al : "R6", int'(alloc_rdy[i]), int'(er));
      if (er) chk((tag_al != "") ? tag_al : "R4", int'(alloc_preg[i]), ep[i]);
      tk[i] = want && er;
      if (tk[i]) av[ep[i]] = 0;
      if (want && !er) chain = 0;
    end
    for (int i = 0; i < NL; i++)
      for (int j = i + 1; j < NL; j++)
        if (tk[i] && tk[j]) chk("R3", int'(alloc_preg[i] == alloc_preg[j]), 0);
    for (int k = 0; k < NL; k++)
      for (int s = 0; s < NS; s++) begin
        a = int'(lk_areg[k][s]);
        if (a == 0) begin ex_p = 0; ex_d = 0; t = "R8"; end
        else begin
          ex_p = m_map[a]; ex_d = m_pend[a]; t = (tag_lk != "") ? tag_lk : "R2";
          for (int m = 0; m < k; m++)
            if (tk[m] && int'(alloc_areg[m]) == a) begin ex_p = ep[m]; ex_d = 1; t = "R5"; end
        end
        chk({t, " preg"}, int'(lk_preg[k][s]), ex_p);
        chk({t, " pend"}, int'(lk_pend[k][s]), ex_d);
      end
    for (int c = 0; c < NC; c++)
      if (comp_val[c])
        for (int r = 1; r < NA; r++) if (m_map[r] == int'(comp_preg[c])) m_pend[r] = 0;
    for (int i = 0; i < NL; i++)
      if (tk[i]) begin
        a = int'(alloc_areg[i]);
        pool[npool] = m_map[a]; npool++;
        m_map[a] = ep[i]; m_pend[a] = 1; m_free[ep[i]] = 0;
      end
    for (int c = 0; c < NF; c++) if (fr_val[c]) m_free[fr_preg[c]] = 1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1..all act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int x, r;
    void'($urandom(32'd4711));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();

    // R1: reset mapping, pending and free list
    for (int g = 0; g < 4; g++) begin
      idle();
      for (int k = 0; k < NL; k++)
        for (int s = 0; s < NS; s++) lk_areg[k][s] = AW'(g * 8 + k * 2 + s);
      tag_lk = "R1";
      if (g == 0) begin alloc_req[0] = 1'b1; alloc_areg[0] = AW'(1); tag_al = "R1"; end
      step();
      tag_al = ""; tag_lk = "";
    end

    // R5: three lanes rename x5, younger lanes read x5
    idle();
    for (int i = 0; i < 3; i++) begin alloc_req[i] = 1'b1; alloc_areg[i] = AW'(5); end
    lk_areg[3][0] = AW'(5); lk_areg[3][1] = AW'(6);
    lk_areg[2][0] = AW'(5); lk_areg[1][0] = AW'(5); lk_areg[0][0] = AW'(5);
    step();

    // R8: request for zero between lanes does not consume or block
    idle();
    alloc_req[0] = 1'b1; alloc_areg[0] = '0;
    alloc_req[1] = 1'b1; alloc_areg[1] = AW'(7);
    tag_al = "R8"; step(); tag_al = "";

    // R7: table written with new register, pending set, youngest wins for x5
    idle(); lk_areg[0][0] = AW'(5); lk_areg[0][1] = AW'(7);
    tag_lk = "R7"; step(); tag_lk = "";

    // R9: completion clears pending next cycle
    idle(); comp_val[0] = 1'b1; comp_preg[0] = PW'(m_map[7]); step();
    idle(); lk_areg[0][0] = AW'(7); lk_areg[0][1] = AW'(5);
    tag_lk = "R9"; step();
    // R9: completion and grant to the same entry together, grant wins
    idle(); comp_val[0] = 1'b1; comp_preg[0] = PW'(m_map[5]);
    alloc_req[0] = 1'b1; alloc_areg[0] = AW'(5); step();
    idle(); lk_areg[1][0] = AW'(5); step(); tag_lk = "";

    // R6: drain the free list completely
    while (m_free != '0) begin
      idle();
      for (int i = 0; i < NL; i++) begin alloc_req[i] = 1'b1; alloc_areg[i] = AW'(9); end
      step();
    end
    idle();
    for (int i = 0; i < NL; i++) begin alloc_req[i] = 1'b1; alloc_areg[i] = AW'(11); end
    tag_al = "R6"; step(); tag_al = "";

    // R10: return one register, it is offered next cycle, only to lane 0
    idle(); x = pop_pool(); fr_val[0] = 1'b1; fr_preg[0] = PW'(x); step();
    idle();
    alloc_req[0] = 1'b1; alloc_areg[0] = AW'(10);
    alloc_req[1] = 1'b1; alloc_areg[1] = AW'(12);
    chk("R10 preg", int'(alloc_preg[0]), x);
    tag_al = "R10"; step(); tag_al = "";

    // Random traffic
    for (int it = 0; it < 3000; it++) begin
      idle();
      for (int i = 0; i < NL; i++) begin
        alloc_req[i] = ($urandom % 2) == 0;
        alloc_areg[i] = AW'($urandom % NA);
        for (int s = 0; s < NS; s++) lk_areg[i][s] = AW'($urandom % NA);
      end
      for (int c = 0; c < NC; c++)
        if ($urandom % 10 < 3) begin
          r = 1 + ($urandom % (NA - 1));
          comp_val[c] = 1'b1; comp_preg[c] = PW'(m_map[r]);
        end
      for (int c = 0; c < NF; c++)
        if (npool > 0 && $urandom % 10 < 4) begin
          fr_val[c] = 1'b1; fr_preg[c] = PW'(pop_pool());
        end
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule